// File: doc/BRIEF.md
# Gapped-Sequence Synchronous JK Counter

This block is a 3-bit synchronous counter that walks a fixed, non-binary loop of five values: 4, 7, 3, 0, 2 and then 4 again. The state is held in three JK flip-flop stages. Stage C is the most significant bit and stage A is the least significant bit. All three stages share one clock and update together on the falling edge, so no bit ripples behind another. Each stage's J and K inputs come from minimised next-state logic. The three codes that are never visited (1, 5 and 6) were treated as don't-cares when that logic was minimised.

A count enable gates the step. While the enable is low, every J and K input is held at zero, so the state stays where it is. An active-high synchronous reset loads the first value of the loop. The load value is a parameter, so an instance can deliberately start in one of the unused codes. The next-state equations pull any unused code back into the loop on the next enabled edge.

Top module: `seq_jk_counter`

## Requirements
- R1: When `rst` is high at a falling clock edge, `state` becomes the parameter `RESET_STATE` (default 4, binary 100) on that edge, whatever the level of `countEn`.
- R2: With `rst` low and `countEn` high, each falling edge moves `state` to the next value of the loop 4 → 7 → 3 → 0 → 2 → 4. `state[2]` is stage C and `state[0]` is stage A.
- R3: `state` changes only at falling clock edges and is stable across the rising edge.
- R4: With `rst` low and `countEn` low, a falling edge leaves `state` unchanged, including when it holds an unused code.
- R5: From an unused code, one enabled falling edge lands `state` in the loop: 1 goes to 2, 5 goes to 3 and 6 goes to 7.
- R6: Once `state` is in the loop, it never takes the values 1, 5 or 6 under any mix of enable and count edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all stages update on its falling edge |
| rst | input | 1 | Synchronous reset, active high, loads `RESET_STATE` |
| countEn | input | 1 | Count enable; low forces every J and K input to zero |
| state | output | 3 | Counter value, C in bit 2, B in bit 1, A in bit 0 |

## Verification
The counter is first run with the enable held high for more than three full loops. Comparing every edge against a table of successors separates a correct loop from a wrong excitation term, because each of the five transitions exercises a different mix of hold, set, reset and toggle. The enable is then alternated edge by edge, which shows whether the hold gating acts on every stage or only on some. A reset is also applied in the middle of the loop, which shows whether reset takes priority over counting. Three more instances start at reset in codes 1, 5 and 6. Their first enabled edge shows whether the don't-care choices really steer each unused code into the loop.

// File: rtl/seq_jk_pkg.sv
package seq_jk_pkg;
  localparam int STAGES = 3;
  localparam int BIT_A = 0;
  localparam int BIT_B = 1;
  localparam int BIT_C = STAGES - 1;

  typedef logic [STAGES-1:0] state_t;

  // Per-stage J and K drive produced by the control logic
  typedef struct packed {
    logic [STAGES-1:0] jDrv;
    logic [STAGES-1:0] kDrv;
  } jkStrobes_t;
endpackage

// File: rtl/jk_stage.sv
module jk_stage #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic jIn,
  input  logic kIn,
  output logic q
);
  // Falling-edge JK cell: hold, clear, set, toggle
  always_ff @(negedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else begin
      unique case ({jIn, kIn})
        2'b00: q <= q;
        2'b01: q <= 1'b0;
        2'b10: q <= 1'b1;
        2'b11: q <= ~q;
      endcase
    end
  end
endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_jk_pkg::*;
(
  input  logic       countEn,
  input  state_t     curState,
  output jkStrobes_t strobes
);
  logic qa, qb, qc;

  assign qa = curState[BIT_A];
  assign qb = curState[BIT_B];
  assign qc = curState[BIT_C];

  // Minimised excitation terms; codes 1, 5 and 6 were free during minimisation
  always_comb begin
    strobes = '0;
    if (countEn) begin
      strobes.jDrv[BIT_A] = qc;
      strobes.kDrv[BIT_A] = ~qc;
      strobes.jDrv[BIT_B] = 1'b1;
      strobes.kDrv[BIT_B] = ~qc;
      strobes.jDrv[BIT_C] = qb & ~qa;
      strobes.kDrv[BIT_C] = qa;
    end
  end
endmodule

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_jk_pkg::*;
#(
  parameter state_t RESET_STATE = 3'd4
) (
  input  logic       clk,
  input  logic       rst,
  input  jkStrobes_t strobes,
  output state_t     curState
);
  for (genvar i = 0; i < STAGES; i++) begin : gStage
    jk_stage #(
      .RST_VAL(RESET_STATE[i])
    ) stage (
      .clk (clk),
      .rst (rst),
      .jIn (strobes.jDrv[i]),
      .kIn (strobes.kDrv[i]),
      .q   (curState[i])
    );
  end
endmodule

// File: rtl/seq_jk_counter.sv
module seq_jk_counter #(
  parameter logic [2:0] RESET_STATE = 3'd4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       countEn,
  output logic [2:0] state
);
  import seq_jk_pkg::*;

  jkStrobes_t strobes;
  state_t     curState;

  seq_ctrl ctrl (
    .countEn  (countEn),
    .curState (curState),
    .strobes  (strobes)
  );

  seq_datapath #(
    .RESET_STATE(RESET_STATE)
  ) dp (
    .clk      (clk),
    .rst      (rst),
    .strobes  (strobes),
    .curState (curState)
  );

  assign state = curState;
endmodule

// File: rtl/seq_jk_counter_chk.sv
module seq_jk_counter_chk #(
  parameter logic [2:0] RESET_STATE = 3'd4
) (
  input logic       clk,
  input logic       rst,
  input logic       countEn,
  input logic [2:0] state
);
  function automatic logic isUnused(input logic [2:0] s);
    return (s == 3'd1) || (s == 3'd5) || (s == 3'd6);
  endfunction

  function automatic logic [2:0] loopNext(input logic [2:0] s);
    case (s)
      3'd4:    return 3'd7;
      3'd7:    return 3'd3;
      3'd3:    return 3'd0;
      3'd0:    return 3'd2;
      3'd2:    return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  // R1
  reset_load_chk: assert property (@(negedge clk)
    (!rst && $past(rst)) |-> (state == RESET_STATE));

  // R2
  loop_step_chk: assert property (@(negedge clk) disable iff (rst)
    (countEn && !isUnused(state)) |=> (state == loopNext($past(state))));

  // R4
  hold_when_idle_chk: assert property (@(negedge clk) disable iff (rst)
    !countEn |=> $stable(state));

  // R5
  unused_recover_chk: assert property (@(negedge clk) disable iff (rst)
    (countEn && isUnused(state)) |=> !isUnused(state));

  // R6
  loop_closed_chk: assert property (@(negedge clk) disable iff (rst)
    !isUnused(state) |=> !isUnused(state));
endmodule

bind seq_jk_counter seq_jk_counter_chk #(.RESET_STATE(RESET_STATE)) chk (.*);

// File: tb/seq_jk_counter_test.sv
module seq_jk_counter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic countEn = 1'b0;
  logic [2:0] stMain, stU1, stU5, stU6;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] main;
    logic [2:0] u1;
    logic [2:0] u5;
    logic [2:0] u6;
    string      tag;
  } expItem_t;

  expItem_t expQ[$];
  logic [2:0] mMain, mU1, mU5, mU6;

  always #4 clk = ~clk;

  seq_jk_counter uut (.clk(clk), .rst(rst), .countEn(countEn), .state(stMain));
  seq_jk_counter #(.RESET_STATE(3'd1)) uutU1 (.clk(clk), .rst(rst), .countEn(countEn), .state(stU1));
  seq_jk_counter #(.RESET_STATE(3'd5)) uutU5 (.clk(clk), .rst(rst), .countEn(countEn), .state(stU5));
  seq_jk_counter #(.RESET_STATE(3'd6)) uutU6 (.clk(clk), .rst(rst), .countEn(countEn), .state(stU6));

  // Successor table from R2 (loop) and R5 (unused codes)
  function automatic logic [2:0] succ(input logic [2:0] s);
    case (s)
      3'd4: return 3'd7;
      3'd7: return 3'd3;
      3'd3: return 3'd0;
      3'd0: return 3'd2;
      3'd2: return 3'd4;
      3'd1: return 3'd2;
      3'd5: return 3'd3;
      default: return 3'd7;
    endcase
  endfunction

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  // Driver: applies inputs at the rising edge, queues what the next falling edge must give
  task automatic step(input logic rstV, input logic enV, input string tag);
    expItem_t it;
    @(posedge clk);
    rst = rstV;
    countEn = enV;
    if (rstV) begin
      mMain = 3'd4; mU1 = 3'd1; mU5 = 3'd5; mU6 = 3'd6;
    end else if (enV) begin
      mMain = succ(mMain); mU1 = succ(mU1); mU5 = succ(mU5); mU6 = succ(mU6);
    end
    it.main = mMain; it.u1 = mU1; it.u5 = mU5; it.u6 = mU6; it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compares 2 ns after each falling edge, then confirms stability past the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (expQ.size() > 0) begin
        expItem_t it;
        logic [2:0] seen;
        it = expQ.pop_front();
        check(it.tag, stMain, it.main);
        check((it.tag == "R1") ? "R1" : "R5", stU1, it.u1);
        check((it.tag == "R1") ? "R1" : "R5", stU5, it.u5);
        check((it.tag == "R1") ? "R1" : "R5", stU6, it.u6);
        if (it.tag == "R2") begin
          // R6: the main counter stays out of codes 1, 5, 6
          checks++;
          if (stMain == 3'd1 || stMain == 3'd5 || stMain == 3'd6) begin
            errors++;
            $display("FAIL R6: got %0d expected a loop value", stMain);
          end
        end
        seen = stMain;
        @(posedge clk);
        #1;
        check("R3", stMain, seen);
      end
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1: reset loads the start value, with enable low and then high
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b1, "R1");
    // R4: idle edges hold, also on the unused-code instances
    step(1'b0, 1'b0, "R4");
    step(1'b0, 1'b0, "R4");
    // R2: more than three loops with the enable held high
    for (int i = 0; i < 17; i++) step(1'b0, 1'b1, "R2");
    // R2/R4: alternating enable
    for (int i = 0; i < 12; i++) step(1'b0, (i % 2) == 0, (i % 2) == 0 ? "R2" : "R4");
    // R1: reset in the middle of a run, enable high
    step(1'b0, 1'b1, "R2");
    step(1'b1, 1'b1, "R1");
    // R5: single enabled edge from each unused code, after idle edges
    step(1'b0, 1'b0, "R4");
    step(1'b0, 1'b1, "R2");
    step(1'b0, 1'b1, "R2");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, "R2");
    while (expQ.size() > 0) @(posedge clk);
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule